// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to 64 level-sensitive interrupt requests. It masks them and picks one winner for the CPU. Software programs it over a simple word bus. Two 32-bit mask words hold one bit per source, and a 1 hides that source. Two byte-wide command ports set or clear a single mask bit by source number. Each source also has an 8-bit control byte holding a level (1 to 7) and a sub-priority (0 to 7). A level of 0 turns the source off.

The controller drives the CPU's priority-level input (`ipl`) with the highest level found among the requesting, unmasked and enabled sources. When the CPU starts an acknowledge for a given level, the controller replies two cycles later with a vector. The vector is 64 plus the index of the strongest source at that level. If no source qualifies at that level, it returns the spurious vector 24. The controller keeps no pending-acknowledge state. A source stays pending until its peripheral drops the request. Bit 0 of the low mask word is a global mask-all bit.

The acknowledge path is a three-state machine:
- ST_IDLE waits for `iack_req` and latches `iack_lvl`, moving to ST_RESOLVE.
- ST_RESOLVE always moves to ST_RESPOND and registers the vector there.
- ST_RESPOND drives `iack_valid` for one cycle and always returns to ST_IDLE.

Top module: `intc_vec_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every control byte is 0, `ipl` is 0 and `iack_valid` is 0.
- R2: The word at address 0x00 holds the mask bits of sources 0..31 (bit i is source i). The word at address 0x04 holds the mask bits of sources 32..63 (bit j is source 32+j). Both are read/write, and a 1 masks the source. Reads return data one cycle after `bus_rd`, and the data holds until the next read. Unmapped addresses read 0, and writes to them are ignored.
- R3: While bit 0 of the low mask word is 1, no source is eligible and `ipl` is 0. Source 0 has no mask bit apart from this global bit.
- R4: Writing n to `bus_wdata[7:0]` at address 0x08 sets the mask bit of source n when n < 64. Values of 64 and above change nothing. Reading 0x08 returns 0.
- R5: Writing n at address 0x0C clears the mask bit of source n when n < 64. Values of 64 and above change nothing. Reading 0x0C returns 0.
- R6: The control byte of source i sits at address 0x40+i. Bits [5:3] hold the level and bits [2:0] the sub-priority. Bits [7:6] are not stored and read as 0.
- R7: A source whose level is 0 never takes part in arbitration.
- R8: A source is eligible when its request is high, its mask bit is 0, the global bit is 0 and its level is non-zero. One cycle after the state changes, `ipl` shows the highest level among eligible sources, or 0 if there are none.
- R9: A high `iack_req` accepted in ST_IDLE gives exactly one `iack_valid` cycle two clock edges later. The vector is 64 plus the index of the eligible source at the latched level with the highest sub-priority, judged at the ST_RESOLVE edge. Among equal sub-priorities the lowest index wins.
- R10: If no eligible source has the latched level (including level 0), the vector is 24. An acknowledge leaves requests pending, so `ipl` is unchanged afterwards.
- R11: `iack_req` seen in ST_RESOLVE or ST_RESPOND is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | NUM_SRC/2 (32) | Write data |
| bus_rdata | output | NUM_SRC/2 (32) | Registered read data |
| irq_req | input | NUM_SRC (64) | Level-sensitive requests, one per source |
| ipl | output | 3 | Highest pending level to the CPU |
| iack_req | input | 1 | Acknowledge start |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_valid | output | 1 | Vector valid, one cycle |
| iack_vec | output | 8 | Acknowledge vector |

## Verification
The bench builds the controller with its default NUM_SRC of 64 and ADDR_W of 8. This reaches three kinds of case: sources in the high mask word, control bytes near the top of the 0x40 window, and source numbers of 64 and above written to the command ports. A behavioural model searches levels and sub-priorities with plain loops and is compared on every clock. Directed cases cover the global mask bit, disabled sources, tied keys, spurious vectors and acknowledge requests issued while the machine is busy.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVL_W = 3;
    localparam int SUB_W = 3;
    localparam int KEY_W = LVL_W + SUB_W;

    localparam int ADDR_MASK_LO = 'h00;
    localparam int ADDR_MASK_HI = 'h04;
    localparam int ADDR_SET     = 'h08;
    localparam int ADDR_CLR     = 'h0C;
    localparam int ADDR_CTRL    = 'h40;

    localparam logic [7:0] VEC_BASE     = 8'd64;
    localparam logic [7:0] VEC_SPURIOUS = 8'd24;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_RESPOND = 2'd2
    } ack_state_e;
endpackage

// File: rtl/intc_mask_regs.sv
module intc_mask_regs #(
    parameter int NUM_SRC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic                 wr_set,
    input  logic                 wr_clr,
    input  logic [NUM_SRC/2-1:0] wdata,
    output logic [NUM_SRC-1:0]   mask
);
    localparam int HALF  = NUM_SRC / 2;
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam logic [7:0] SRC_LIM = 8'(NUM_SRC);

    logic             num_ok;
    logic [IDX_W-1:0] num;

    assign num_ok = (wdata[7:0] < SRC_LIM);
    assign num    = wdata[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else begin
            if (wr_lo)
                mask[HALF-1:0] <= wdata;
            if (wr_hi)
                mask[NUM_SRC-1:HALF] <= wdata;
            if (wr_set && num_ok)
                mask[num] <= 1'b1;
            if (wr_clr && num_ok)
                mask[num] <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic [$clog2(NUM_SRC)-1:0]        idx,
    input  logic [7:0]                        wdata,
    output logic [NUM_SRC-1:0][KEY_W-1:0]     keys
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                keys[i] <= '0;
            else if (wr && (int'(idx) == i))
                keys[i] <= wdata[KEY_W-1:0];
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]            elig,
    input  logic [NUM_SRC-1:0][KEY_W-1:0] keys,
    input  logic                          filt_en,
    input  logic [LVL_W-1:0]              filt_lvl,
    output logic                          found,
    output logic [$clog2(NUM_SRC)-1:0]    win_idx,
    output logic [KEY_W-1:0]              win_key
);
    localparam int IDX_W = $clog2(NUM_SRC);

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_key = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] &&
                (!filt_en || keys[i][KEY_W-1 -: LVL_W] == filt_lvl) &&
                (!found || keys[i] > win_key)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_key = keys[i];
            end
        end
    end
endmodule

// File: rtl/intc_vec_ctrl.sv
module intc_vec_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [NUM_SRC/2-1:0]   bus_wdata,
    output logic [NUM_SRC/2-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]     irq_req,
    output logic [2:0]             ipl,
    input  logic                   iack_req,
    input  logic [2:0]             iack_lvl,
    output logic                   iack_valid,
    output logic [7:0]             iack_vec
);
    localparam int DATA_W = NUM_SRC / 2;
    localparam int IDX_W  = $clog2(NUM_SRC);

    // address decode
    logic hit_lo, hit_hi, hit_set, hit_clr, hit_ctrl;
    logic [ADDR_W-1:0] ctrl_off;
    logic [IDX_W-1:0]  ctrl_idx;

    assign hit_lo   = (bus_addr == ADDR_W'(ADDR_MASK_LO));
    assign hit_hi   = (bus_addr == ADDR_W'(ADDR_MASK_HI));
    assign hit_set  = (bus_addr == ADDR_W'(ADDR_SET));
    assign hit_clr  = (bus_addr == ADDR_W'(ADDR_CLR));
    assign hit_ctrl = (int'(bus_addr) >= ADDR_CTRL) &&
                      (int'(bus_addr) <  ADDR_CTRL + NUM_SRC);
    assign ctrl_off = bus_addr - ADDR_W'(ADDR_CTRL);
    assign ctrl_idx = ctrl_off[IDX_W-1:0];

    // storage
    logic [NUM_SRC-1:0]            mask_q;
    logic [NUM_SRC-1:0][KEY_W-1:0] keys;

    intc_mask_regs #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (bus_wr && hit_lo),
        .wr_hi  (bus_wr && hit_hi),
        .wr_set (bus_wr && hit_set),
        .wr_clr (bus_wr && hit_clr),
        .wdata  (bus_wdata),
        .mask   (mask_q)
    );

    intc_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && hit_ctrl),
        .idx   (ctrl_idx),
        .wdata (bus_wdata[7:0]),
        .keys  (keys)
    );

    // eligibility: requesting, unmasked, global bit clear, level non-zero
    logic [NUM_SRC-1:0] elig;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = irq_req[i] && !mask_q[i] && !mask_q[0] &&
                         (keys[i][KEY_W-1 -: LVL_W] != '0);
    end

    // global winner drives the level output
    logic             top_found;
    logic [IDX_W-1:0] top_idx;
    logic [KEY_W-1:0] top_key;

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb_top (
        .elig     (elig),
        .keys     (keys),
        .filt_en  (1'b0),
        .filt_lvl ('0),
        .found    (top_found),
        .win_idx  (top_idx),
        .win_key  (top_key)
    );

    // acknowledge state machine
    ack_state_e       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [7:0]       vec_q;
    logic             ack_found;
    logic [IDX_W-1:0] ack_idx;
    logic [KEY_W-1:0] ack_key;

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb_ack (
        .elig     (elig),
        .keys     (keys),
        .filt_en  (1'b1),
        .filt_lvl (lvl_q),
        .found    (ack_found),
        .win_idx  (ack_idx),
        .win_key  (ack_key)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = iack_req ? ST_RESOLVE : ST_IDLE;
            ST_RESOLVE: state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            vec_q <= '0;
        end else begin
            if (state_q == ST_IDLE && iack_req)
                lvl_q <= iack_lvl;
            if (state_q == ST_RESOLVE)
                vec_q <= ack_found ? (VEC_BASE + 8'(ack_idx)) : VEC_SPURIOUS;
        end
    end

    always_comb begin
        iack_valid = (state_q == ST_RESPOND);
        iack_vec   = iack_valid ? vec_q : 8'd0;
    end

    // level output and read data
    logic [2:0]        ipl_q;
    logic [DATA_W-1:0] rdata_q, rd_mux;

    always_comb begin
        rd_mux = '0;
        if (hit_lo)
            rd_mux = mask_q[DATA_W-1:0];
        else if (hit_hi)
            rd_mux = mask_q[NUM_SRC-1:DATA_W];
        else if (hit_ctrl)
            rd_mux = DATA_W'(keys[ctrl_idx]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipl_q   <= '0;
            rdata_q <= '0;
        end else begin
            ipl_q <= top_found ? top_key[KEY_W-1 -: LVL_W] : '0;
            if (bus_rd)
                rdata_q <= rd_mux;
        end
    end

    assign ipl       = ipl_q;
    assign bus_rdata = rdata_q;
endmodule

// File: rtl/intc_vec_ctrl_chk.sv
module intc_vec_ctrl_chk
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_SRC/2-1:0] bus_wdata,
    input logic                 iack_req,
    input logic                 iack_valid,
    input logic [7:0]           iack_vec,
    input logic [2:0]           ipl,
    input logic [NUM_SRC-1:0]   mask_q
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam logic [7:0] SRC_LIM = 8'(NUM_SRC);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        iack_valid |=> !iack_valid);

    a_r9_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        iack_valid |-> $past(iack_req, 2));

    a_r10_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        iack_valid |-> (iack_vec == VEC_SPURIOUS || iack_vec[7:6] == 2'b01));

    a_r3_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[0] |=> (ipl == 3'd0));

    a_r4_set_port: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADDR_SET) && bus_wdata[7:0] < SRC_LIM)
        |=> mask_q[$past(bus_wdata[IDX_W-1:0])]);

    a_r5_clr_port: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADDR_CLR) && bus_wdata[7:0] < SRC_LIM)
        |=> !mask_q[$past(bus_wdata[IDX_W-1:0])]);
endmodule

bind intc_vec_ctrl intc_vec_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .iack_req   (iack_req),
    .iack_valid (iack_valid),
    .iack_vec   (iack_vec),
    .ipl        (ipl),
    .mask_q     (mask_q)
);

// File: tb/intc_vec_ctrl_test.sv
`timescale 1ns/1ps
module intc_vec_ctrl_test;
    localparam int N = 64;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  irq_req = '0;
    logic [2:0]    ipl;
    logic          iack_req = 1'b0;
    logic [2:0]    iack_lvl = '0;
    logic          iack_valid;
    logic [7:0]    iack_vec;

    always #2 clk = ~clk;

    intc_vec_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .ipl(ipl), .iack_req(iack_req), .iack_lvl(iack_lvl),
        .iack_valid(iack_valid), .iack_vec(iack_vec)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_mask;
    logic [5:0]   m_key [N];
    int           m_st, m_lvl, m_vec, m_ipl;
    logic [DW-1:0] m_rdata;

    function automatic bit m_elig(int i);
        return irq_req[i] && !m_mask[i] && !m_mask[0] && (m_key[i][5:3] != 0);
    endfunction

    function automatic int m_find(int lv);
        for (int sub = 7; sub >= 0; sub--)
            for (int i = 0; i < N; i++)
                if (m_elig(i) && int'(m_key[i][5:3]) == lv && int'(m_key[i][2:0]) == sub)
                    return i;
        return -1;
    endfunction

    function automatic logic [DW-1:0] m_read(int a);
        if (a == 'h00) return m_mask[31:0];
        if (a == 'h04) return m_mask[63:32];
        if (a >= 'h40 && a < 'h40 + N) return DW'(m_key[a - 'h40]);
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '1;
            for (int i = 0; i < N; i++) m_key[i] = '0;
            m_st = 0; m_lvl = 0; m_vec = 0; m_ipl = 0; m_rdata = '0;
        end else begin
            int nxt_ipl, s;
            nxt_ipl = 0;
            for (int lv = 7; lv >= 1; lv--)
                if (nxt_ipl == 0 && m_find(lv) >= 0) nxt_ipl = lv;
            case (m_st)
                0: if (iack_req) begin m_lvl = int'(iack_lvl); m_st = 1; end
                1: begin s = m_find(m_lvl); m_vec = (s < 0) ? 24 : 64 + s; m_st = 2; end
                default: m_st = 0;
            endcase
            if (bus_rd) m_rdata = m_read(int'(bus_addr));
            if (bus_wr) begin
                int a, v;
                a = int'(bus_addr); v = int'(bus_wdata[7:0]);
                if (a == 'h00) m_mask[31:0] = bus_wdata;
                else if (a == 'h04) m_mask[63:32] = bus_wdata;
                else if (a == 'h08 && v < N) m_mask[v] = 1'b1;
                else if (a == 'h0C && v < N) m_mask[v] = 1'b0;
                else if (a >= 'h40 && a < 'h40 + N) m_key[a - 'h40] = bus_wdata[5:0];
            end
            m_ipl = nxt_ipl;
        end
    end

    // per-clock comparison, sampled away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(ipl == 3'(m_ipl), "R8 ipl vs model", ipl, m_ipl);
            chk(iack_valid == (m_st == 2), "R9 iack_valid vs model", iack_valid, m_st == 2);
            if (m_st == 2)
                chk(iack_vec == 8'(m_vec), "R9 iack_vec vs model", iack_vec, m_vec);
            chk(bus_rdata == m_rdata, "R2 rdata vs model", bus_rdata, m_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = DW'(d);
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 8'(a);
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic ack(input int lv, output logic [7:0] v, output bit vld);
        @(negedge clk); iack_req = 1'b1; iack_lvl = 3'(lv);
        @(negedge clk); iack_req = 1'b0;
        @(negedge clk); v = iack_vec; vld = iack_valid;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    logic [DW-1:0] d;
    logic [7:0]    v;
    bit            vld;

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ipl == 0, "R1 ipl after reset", ipl, 0);
        chk(iack_valid == 0, "R1 iack_valid after reset", iack_valid, 0);
        rd('h00, d); chk(d == 32'hFFFF_FFFF, "R1 mask low reset", d, 32'hFFFF_FFFF);
        rd('h04, d); chk(d == 32'hFFFF_FFFF, "R1 mask high reset", d, 32'hFFFF_FFFF);
        rd('h40 + 63, d); chk(d == 0, "R1 control byte reset", d, 0);

        wr('h40 + 5, 'h1A);   // level 3 sub 2
        wr('h40 + 40, 'h1E);  // level 3 sub 6
        wr('h40 + 10, 'h28);  // level 5 sub 0
        wr('h40 + 20, 'h05);  // level 0
        irq_req[5] = 1; irq_req[10] = 1; irq_req[20] = 1; irq_req[40] = 1;
        settle(); chk(ipl == 0, "R3 all masked at reset", ipl, 0);

        wr('h0C, 5); wr('h0C, 10); wr('h0C, 20); wr('h0C, 40);
        settle(); chk(ipl == 0, "R3 global bit still set", ipl, 0);
        rd('h00, d); chk(d == 32'hFFEF_FBDF, "R5 clear port low", d, 32'hFFEF_FBDF);
        rd('h04, d); chk(d == 32'hFFFF_FEFF, "R5 clear port high", d, 32'hFFFF_FEFF);

        wr('h0C, 0);
        settle(); chk(ipl == 5, "R8 highest level", ipl, 5);

        ack(5, v, vld); chk(vld && v == 74, "R9 ack level 5", v, 74);
        ack(3, v, vld); chk(vld && v == 104, "R9 sub-priority wins", v, 104);
        ack(6, v, vld); chk(vld && v == 24, "R10 spurious level 6", v, 24);
        settle(); chk(ipl == 5, "R10 request stays pending", ipl, 5);

        wr('h08, 10);
        settle(); chk(ipl == 3, "R4 set port masks source", ipl, 3);
        rd('h08, d); chk(d == 0, "R4 set port reads 0", d, 0);
        wr('h08, 70);
        rd('h00, d); chk(d == 32'hFFEF_FFDE, "R4 out-of-range set low", d, 32'hFFEF_FFDE);
        rd('h04, d); chk(d == 32'hFFFF_FEFF, "R4 out-of-range set high", d, 32'hFFFF_FEFF);
        wr('h0C, 200);
        rd('h00, d); chk(d == 32'hFFEF_FFDE, "R5 out-of-range clear", d, 32'hFFEF_FFDE);
        rd('h0C, d); chk(d == 0, "R5 clear port reads 0", d, 0);

        irq_req[40] = 0;
        ack(3, v, vld); chk(vld && v == 69, "R9 remaining level 3 source", v, 69);

        wr('h40 + 7, 'hFF);
        rd('h40 + 7, d); chk(d == 'h3F, "R6 upper control bits read 0", d, 'h3F);
        rd('h20, d); chk(d == 0, "R2 unmapped reads 0", d, 0);

        irq_req[5] = 0;
        settle(); chk(ipl == 0, "R7 level 0 source ignored", ipl, 0);
        ack(0, v, vld); chk(vld && v == 24, "R7 level 0 ack spurious", v, 24);

        wr('h00, 0); wr('h04, 'hFFFF_FFFF);
        irq_req[5] = 1; irq_req[40] = 1;
        settle(); chk(ipl == 5, "R2 mask word write", ipl, 5);
        ack(3, v, vld); chk(vld && v == 69, "R2 high mask hides source 40", v, 69);

        wr('h40 + 6, 'h1A); irq_req[6] = 1;
        ack(3, v, vld); chk(vld && v == 69, "R9 tie lowest index", v, 69);

        begin
            int pulses;
            pulses = 0;
            @(negedge clk); iack_req = 1'b1; iack_lvl = 3'd3;
            @(negedge clk);
            @(negedge clk); iack_req = 1'b0;
            if (iack_valid) pulses++;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (iack_valid) pulses++;
            end
            chk(pulses == 1, "R11 busy request ignored", pulses, 1);
        end

        settle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule